// File: doc/BRIEF.md
# Clock Output Select and Gating Controller

This block sits between a clock generator's control registers and its eight clock outputs. It turns two 8-bit control words and a handful of board pins into the signals the rest of the generator needs. These are a 4-bit frequency code for the synthesizer, two spread-spectrum flags for the modulator, eight gated copies of the synthesized clocks, and one output-drive enable. The synthesizer and the modulator are outside this block.

The frequency code comes from one of two places. It can come from four board strap pins, which are first synchronized into the control clock domain. It can also come from four bits of the main control word, which are spread over non-adjacent positions. Code 0 asks for the fastest output (133.34 MHz), code 6 for 100 MHz, code 12 for 66.67 MHz and code 15 for the slowest (33.33 MHz).

Each clock output is gated by its own run bit and by a global active-low stop pin. The gate is closed and opened only while that output's own clock is low. A separate drive-disable bit takes the whole output bank to high impedance. All control pins are plain level signals. No data stream crosses this block, so there is no valid/ready handshake and no back-pressure.

Top module: `clkout_ctrl`

## Requirements
- R1: When main-word bit 3 is 0, `freq_code` equals `fs_pin` as sampled through a two-flop synchronizer, so it reflects the pins two control-clock edges later.
- R2: When main-word bit 3 is 1, `freq_code` is {bit 2, bit 6, bit 5, bit 4} of the main word, with bit 2 as the most significant bit.
- R3: `spread_on` follows main-word bit 1, where 1 means on. `spread_deep` follows main-word bit 7, where 0 means down-spread to -0.5% and 1 means down-spread to -1.0%.
- R4: `out_en` is the inverse of main-word bit 0. A 1 in that bit deasserts `out_en` whatever the run bits and the stop pin are.
- R5: Run-word bit n controls `clk_out[n]`. A 1 means the output copies `clk_in[n]`, and a 0 means it is held low.
- R6: While the synchronized `stop_n` is low, all eight outputs are held low whatever the run word says. The stop pin passes through a two-flop synchronizer in the control domain.
- R7: After the internal enable of an output drops, that output is low within three cycles of its own clock. After the enable rises, the output again copies its clock within three cycles.
- R8: No runt pulses. `clk_out[n]` is never high while `clk_in[n]` is low, and a high phase of `clk_out[n]` is never cut short or started partway through a high phase of `clk_in[n]`.
- R9: During reset all clock outputs are low and the synchronized pin code reads 0. With main word 0x00, run word 0xFF and `stop_n` high, all eight outputs run after reset and the code follows the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_main | input | 8 | Main control word (source select, code bits, spread, depth, drive disable) |
| cfg_run | input | 8 | Per-output run bits, bit n for output n |
| fs_pin | input | 4 | Frequency strap pins, asynchronous |
| stop_n | input | 1 | Global active-low clock stop, asynchronous |
| clk_in | input | 8 | Synthesized clocks to be gated |
| freq_code | output | 4 | Selected frequency code for the synthesizer |
| spread_on | output | 1 | Spread-spectrum enable for the modulator |
| spread_deep | output | 1 | Spread depth select for the modulator |
| clk_out | output | 8 | Gated clocks |
| out_en | output | 1 | Output drive enable, 0 means high impedance |

## Verification
Two functions can act on an output in the same control cycle. The global stop pin can release while the run word changes, and the drive-disable bit can be set while the stop pin asserts. Both cases are provoked by driving the two changes on the same control-clock edge, and also inside random mixes of the words and pins. The result is judged from the final state of each output, taken over a window that covers a full period of the slowest clock. It must match the run bit ANDed with the stop level, and `out_en` must follow only the drive-disable bit. A second sampled window is opened while the gates are switching, to look for clipped or runt high phases.

// File: rtl/clkout_ctrl_pkg.sv
`timescale 1ns/1ps
package clkout_ctrl_pkg;
  localparam int CODE_W     = 4;
  localparam int CFG_W      = 8;
  // positions that the synthesizer and modulator rely on
  localparam int POS_HIZ    = 0;
  localparam int POS_SPREAD = 1;
  localparam int POS_SRC    = 3;
  localparam int POS_DEPTH  = 7;

  typedef enum logic { SRC_PINS = 1'b0, SRC_REG = 1'b1 } code_src_e;

  // gather the scattered register code bits, bit 2 is the MSB
  function automatic logic [CODE_W-1:0] reg_code(input logic [CFG_W-1:0] w);
    return {w[2], w[6], w[5], w[4]};
  endfunction
endpackage

// File: rtl/clkout_sync.sv
`timescale 1ns/1ps
module clkout_sync #(
  parameter int          WIDTH   = 1,
  parameter int          STAGES  = 2,
  parameter logic [0:0]  RST_BIT = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= {WIDTH{RST_BIT}};
    else        chain[0] <= d_async;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= {WIDTH{RST_BIT}};
      else        chain[s] <= chain[s-1];
    end
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/clkout_freq_sel.sv
`timescale 1ns/1ps
module clkout_freq_sel
  import clkout_ctrl_pkg::*;
(
  input  logic [CFG_W-1:0]  cfg_main,
  input  logic [CODE_W-1:0] fs_synced,
  output logic [CODE_W-1:0] freq_code,
  output logic              spread_on,
  output logic              spread_deep,
  output logic              out_en
);
  code_src_e src;

  always_comb begin
    src = code_src_e'(cfg_main[POS_SRC]);
    unique case (src)
      SRC_REG:  freq_code = reg_code(cfg_main);
      default:  freq_code = fs_synced;
    endcase
    spread_on   = cfg_main[POS_SPREAD];
    spread_deep = cfg_main[POS_DEPTH];
    out_en      = ~cfg_main[POS_HIZ];
  end
endmodule

// File: rtl/clkout_gate_cell.sv
`timescale 1ns/1ps
module clkout_gate_cell #(
  parameter int STAGES = 2
) (
  input  logic clk_src,
  input  logic rst_n,
  input  logic en_async,
  output logic clk_gated
);
  // enable re-timed on the falling edge of the clock it gates,
  // so the gate state only moves while clk_src is low
  logic [STAGES-1:0] en_pipe;

  always_ff @(negedge clk_src or negedge rst_n) begin
    if (!rst_n) en_pipe <= '0;
    else        en_pipe <= {en_pipe[STAGES-2:0], en_async};
  end

  assign clk_gated = clk_src & en_pipe[STAGES-1];
endmodule

// File: rtl/clkout_ctrl.sv
`timescale 1ns/1ps
module clkout_ctrl
  import clkout_ctrl_pkg::*;
#(
  parameter int N_CLK     = 8,
  parameter int SYNC_LEN  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  cfg_main,
  input  logic [N_CLK-1:0]  cfg_run,
  input  logic [CODE_W-1:0] fs_pin,
  input  logic              stop_n,
  input  logic [N_CLK-1:0]  clk_in,
  output logic [CODE_W-1:0] freq_code,
  output logic              spread_on,
  output logic              spread_deep,
  output logic [N_CLK-1:0]  clk_out,
  output logic              out_en
);
  logic [CODE_W-1:0] fs_synced;
  logic              stop_synced;
  logic [N_CLK-1:0]  en_ctrl;

  clkout_sync #(.WIDTH(CODE_W), .STAGES(SYNC_LEN), .RST_BIT(1'b0)) u_fs_sync (
    .clk(clk), .rst_n(rst_n), .d_async(fs_pin), .q_sync(fs_synced)
  );

  clkout_sync #(.WIDTH(1), .STAGES(SYNC_LEN), .RST_BIT(1'b1)) u_stop_sync (
    .clk(clk), .rst_n(rst_n), .d_async(stop_n), .q_sync(stop_synced)
  );

  clkout_freq_sel u_sel (
    .cfg_main(cfg_main), .fs_synced(fs_synced), .freq_code(freq_code),
    .spread_on(spread_on), .spread_deep(spread_deep), .out_en(out_en)
  );

  // registered so that a glitch-free level crosses into each clock domain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_ctrl <= '0;
    else        en_ctrl <= cfg_run & {N_CLK{stop_synced}};
  end

  for (genvar i = 0; i < N_CLK; i++) begin : g_gate
    clkout_gate_cell #(.STAGES(SYNC_LEN)) u_cell (
      .clk_src(clk_in[i]), .rst_n(rst_n), .en_async(en_ctrl[i]),
      .clk_gated(clk_out[i])
    );
  end
endmodule

// File: rtl/clkout_ctrl_chk.sv
`timescale 1ns/1ps
module clkout_ctrl_chk #(
  parameter int N_CLK = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       cfg_main,
  input logic [3:0]       fs_pin,
  input logic             stop_n,
  input logic [N_CLK-1:0] clk_in,
  input logic [N_CLK-1:0] clk_out,
  input logic [3:0]       freq_code,
  input logic             out_en,
  input logic [N_CLK-1:0] en_ctrl
);
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_rst <= '0;
    else if (since_rst != 3) since_rst <= since_rst + 2'd1;
  end

  AST_CODE_FROM_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2 && !cfg_main[3]) |-> freq_code == $past(fs_pin, 2)); // R1

  AST_CODE_FROM_REG: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_main[3] |-> (freq_code[3] == cfg_main[2] && freq_code[0] == cfg_main[4])); // R2

  AST_HIZ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_main[0] |-> !out_en); // R4

  AST_STOP_GATES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 3 && !$past(stop_n, 3)) |-> en_ctrl == '0); // R6

  for (genvar i = 0; i < N_CLK; i++) begin : g_ch
    logic [1:0] off_cnt;
    always_ff @(negedge clk_in[i] or negedge rst_n) begin
      if (!rst_n)           off_cnt <= '0;
      else if (en_ctrl[i])  off_cnt <= '0;
      else if (off_cnt != 3) off_cnt <= off_cnt + 2'd1;
    end

    AST_STOPPED_LOW: assert property (@(negedge clk_in[i]) disable iff (!rst_n)
      (off_cnt >= 2) |-> !clk_out[i]); // R7

    AST_NO_RUNT: assert property (@(posedge clk_in[i]) disable iff (!rst_n)
      !clk_out[i]); // R8
  end
endmodule

bind clkout_ctrl clkout_ctrl_chk #(.N_CLK(N_CLK)) u_chk (.*);

// File: tb/clkout_ctrl_bench.sv
`timescale 1ns/100ps
module clkout_ctrl_bench;
  localparam real CLK_PERIOD = 10.0;
  localparam int  N_CLK      = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [7:0]       cfg_main = 8'h00;
  logic [7:0]       cfg_run  = 8'hFF;
  logic [3:0]       fs_pin   = 4'hA;
  logic             stop_n   = 1'b1;
  logic [N_CLK-1:0] clk_in   = '0;
  logic [3:0]       freq_code;
  logic             spread_on, spread_deep, out_en;
  logic [N_CLK-1:0] clk_out;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // half periods 3,5,...,17 ns; edges on integer ns
  for (genvar g = 0; g < N_CLK; g++) begin : g_src
    initial forever #(3 + 2*g) clk_in[g] = ~clk_in[g];
  end

  clkout_ctrl u_clkout_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_main(cfg_main), .cfg_run(cfg_run),
    .fs_pin(fs_pin), .stop_n(stop_n), .clk_in(clk_in), .freq_code(freq_code),
    .spread_on(spread_on), .spread_deep(spread_deep), .clk_out(clk_out),
    .out_en(out_en)
  );

  function automatic logic [3:0] exp_code(input logic [7:0] m, input logic [3:0] fs);
    return m[3] ? {m[2], m[6], m[5], m[4]} : fs;
  endfunction

  function automatic logic [7:0] exp_gate(input logic [7:0] run, input logic stp);
    return stp ? run : 8'h00;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] m, input logic [7:0] r,
                       input logic [3:0] fs, input logic stp);
    @(negedge clk);
    cfg_main = m; cfg_run = r; fs_pin = fs; stop_n = stp;
    repeat (20) @(negedge clk);
    #0.5;
  endtask

  task automatic check_ctrl(input string tag);
    check({tag, " R1/R2 code"}, freq_code, exp_code(cfg_main, fs_pin));
    check({tag, " R3 spread"}, {spread_deep, spread_on}, {cfg_main[7], cfg_main[1]});
    check({tag, " R4 out_en"}, out_en, !cfg_main[0]);
  endtask

  // steady-state window: one period of the slowest clock and more
  task automatic check_gates(input string tag);
    logic [7:0] want = exp_gate(cfg_run, stop_n);
    logic [7:0] bad  = '0;
    for (int s = 0; s < 40; s++) begin
      for (int i = 0; i < N_CLK; i++)
        if (clk_out[i] !== (want[i] ? clk_in[i] : 1'b0)) bad[i] = 1'b1;
      #1;
    end
    check({tag, " R5/R6/R7 gate window"}, bad, 8'h00);
  endtask

  // transition window: no clipped or runt high phase (R8)
  task automatic runt_window(input logic [7:0] r);
    logic [7:0] p_in  = clk_in;
    logic [7:0] p_out = clk_out;
    logic [7:0] bad   = '0;
    cfg_run = r;
    for (int s = 0; s < 300; s++) begin
      #1;
      for (int i = 0; i < N_CLK; i++) begin
        if (clk_out[i] && !clk_in[i]) bad[i] = 1'b1;
        if (p_in[i] && clk_in[i] && (p_out[i] !== clk_out[i])) bad[i] = 1'b1;
      end
      p_in = clk_in; p_out = clk_out;
    end
    check("R8 no runt while switching", bad, 8'h00);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    // R9 reset state
    repeat (3) @(negedge clk);
    #0.5;
    check("R9 reset code", freq_code, 4'h0);
    begin
      logic [7:0] hi = '0;
      for (int s = 0; s < 40; s++) begin hi |= clk_out; #1; end
      check("R9 reset outputs low", hi, 8'h00);
    end
    @(negedge clk); rst_n = 1'b1;
    repeat (20) @(negedge clk); #0.5;
    check("R9 default code from pins", freq_code, 4'hA);
    check("R9 default spread off", spread_on, 1'b0);
    check_gates("R9 defaults all run");

    // directed corners
    apply(8'h08, 8'hFF, 4'h0, 1'b1); check("R2 all-zero reg code", freq_code, 4'h0);
    apply(8'h7C, 8'hFF, 4'h0, 1'b1); check("R2 code 15", freq_code, 4'hF);
    apply(8'h6C, 8'hFF, 4'h3, 1'b1); check("R2 code 14 MSB order", freq_code, 4'hE);
    apply(8'h50, 8'hFF, 4'h6, 1'b1); check("R1 ignores reg bits", freq_code, 4'h6);
    apply(8'h82, 8'hA5, 4'hC, 1'b1); check_ctrl("R3 deep spread"); check_gates("R5 pattern A5");
    apply(8'h00, 8'hFF, 4'hC, 1'b0); check_gates("R6 stop overrides all-run");
    // same-edge: stop releases while run word changes
    apply(8'h00, 8'h3C, 4'hC, 1'b1); check_gates("R6 release with run change");
    // same-edge: drive disable while stop asserts
    apply(8'h01, 8'hFF, 4'h2, 1'b0); check("R4 hi-z with stop", out_en, 1'b0);
    check_gates("R6 stop under hi-z");
    apply(8'h01, 8'hFF, 4'h2, 1'b1); check("R4 hi-z while running", out_en, 1'b0);
    check_gates("R7 restart after stop");

    // R8 switching windows
    apply(8'h00, 8'h00, 4'h0, 1'b1);
    runt_window(8'hFF);
    runt_window(8'h00);
    runt_window(8'h5A);

    // constrained random
    for (int k = 0; k < 30; k++) begin
      logic [7:0] m  = 8'($urandom);
      logic [7:0] r  = 8'($urandom);
      logic [3:0] fs = 4'($urandom);
      logic       st = ($urandom % 4) != 0;
      apply(m, r, fs, st);
      check_ctrl("rand");
      check_gates("rand");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule